// File: doc/BRIEF.md
# Low-Power Mode and Wake-up Controller

This block decides how a small microcontroller sleeps and how it comes back. When the CPU raises a stop request, the controller looks at the wake-enable field of its clock control register. With that field clear it enters full stop: the oscillator enable drops, the CPU clock is gated, and only a hardware reset brings the chip back. With that field set it enters timed sleep instead. In timed sleep the oscillator keeps running and the CPU clock is gated. A prescaler and a period timer keep counting, and the controller wakes when the timer reaches its programmed period or when an external interrupt arrives.

On a wake that is not caused by reset, the CPU clock restarts on the same edge that ends sleep, because the oscillator never stopped. The controller raises one of two one-cycle cause pulses. If the global interrupt-enable flag is set, it asks the CPU to take the interrupt vector. Otherwise it tells the CPU to resume at the instruction after the stop. A hardware reset clears the control and period registers. Internal reset then stays asserted for a fixed count of oscillator cycles so the oscillator can settle, and software has no way to change that count.

Top module: `lpm_wake_ctrl`

## Requirements
- R1: A stop request with wake-enable (control bit 0) set enters timed sleep on the next edge: `cpu_clk_en_o` goes low and `osc_en_o` stays high.
- R2: A stop request with wake-enable clear enters full stop: `cpu_clk_en_o` and `osc_en_o` both go low. External interrupts have no effect in full stop, and only hardware reset leaves it.
- R3: Timer clock select is control bits 2:1, and the value 2'b11 picks the wake tap of 2^WAKE_DIV_LOG2 cycles. With that tap, timed sleep ends by itself exactly (P+1)·2^WAKE_DIV_LOG2 cycles after the entry edge, where P is the period register 0 value.
- R4: In timed sleep, any clock select other than 2'b11 never produces a timer wake.
- R5: With the cascade bit (control bit 3) set, the period is the 16-bit value {period register 1, period register 0}, and the sleep length becomes (P16+1)·2^WAKE_DIV_LOG2 cycles.
- R6: An external interrupt sampled high during timed sleep ends the sleep on that edge.
- R7: On a non-reset wake, exactly one cause pulse is raised, lasting one cycle. `wake_vec_o` is raised when `ien_i` was 1 at the exit edge, and `wake_resume_o` when it was 0.
- R8: A non-reset wake needs no stabilization wait: `cpu_clk_en_o` is high in the same cycle as the cause pulse.
- R9: After `rst_n_i` is released, `int_rst_o` stays high for exactly 2^STAB_W clock edges and `cpu_clk_en_o` stays low meanwhile. Reset clears the control register and both period registers.
- R10: A non-reset wake keeps the control register and period registers, so a repeated stop needs no reprogramming.
- R11: Only a full-byte write (`ctl_byte_wr_i` high, `ctl_bit_wr_i` low) updates the control register. A single-bit strobe leaves it unchanged.
- R12: A stop request that arrives while `int_rst_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_n_i | input | 1 | Hardware reset, active low, asynchronous |
| stop_req_i | input | 1 | Stop instruction executed (one-cycle pulse) |
| ien_i | input | 1 | Global interrupt-enable flag of the CPU |
| ext_irq_i | input | 1 | External interrupt request |
| ctl_byte_wr_i | input | 1 | Full-byte write strobe for the control register |
| ctl_bit_wr_i | input | 1 | Single-bit set/clear strobe for the control register (ignored) |
| tdr0_wr_i | input | 1 | Write strobe for period register 0 |
| tdr1_wr_i | input | 1 | Write strobe for period register 1 |
| wdata_i | input | TW | Write data |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| int_rst_o | output | 1 | Internal reset, active high |
| wake_vec_o | output | 1 | One-cycle pulse: take the interrupt vector |
| wake_resume_o | output | 1 | One-cycle pulse: resume in line after the stop |

## Verification
The bench times each timed sleep to the exact cycle, including a period of zero, a period of 255, and a cascaded period. A timer that counted one tick too many or too few, or that kept the prescaler phase from before sleep, would wake off by a multiple of the tap length. Timed sleep is also run with a non-wake tap selected, where a design that ignored the tap select would wake by itself. Full stop receives external interrupts, and a design that let them through would restart the CPU clock without any settling time. Bit strobes and stop requests during the settling window are applied and then observed at the ports. A design that honoured either would sleep in the wrong flavour, or would not be running once reset ends.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        LPM_RUN       = 2'd0,
        LPM_WAKE_TMR  = 2'd1,
        LPM_FULL_STOP = 2'd2
    } lpm_state_e;

    // clock control field layout: bit0 wake enable, bits2:1 tap select, bit3 cascade
    typedef struct packed {
        logic       cascade;
        logic [1:0] t0_sel;
        logic       wake_en;
    } lpm_ctl_t;

    localparam logic [1:0] SEL_WAKE_TAP = 2'b11;
    localparam int         CTL_W        = 4;
    localparam int         N_TAPS       = 4;

endpackage

// File: rtl/lpm_prescaler.sv
module lpm_prescaler #(
    parameter int WAKE_DIV_LOG2 = 11
) (
    input  logic       clk_i,
    input  logic       rst_n_i,
    input  logic       run_i,
    input  logic       clr_i,
    input  logic       wake_only_i,
    input  logic [1:0] sel_i,
    output logic       tick_o
);
    import lpm_pkg::*;

    localparam int PS_W = (WAKE_DIV_LOG2 > 5) ? WAKE_DIV_LOG2 : 5;

    logic [PS_W-1:0]   cnt_d, cnt_q;
    logic [N_TAPS-1:0] tap_hit;

    for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
        localparam int TAP_LOG2 = (i == 0) ? 1 :
                                  (i == 1) ? 3 :
                                  (i == 2) ? 5 : WAKE_DIV_LOG2;
        assign tap_hit[i] = &cnt_q[TAP_LOG2-1:0];
    end

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (run_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick_o = run_i && !clr_i && tap_hit[sel_i]
                    && (!wake_only_i || (sel_i == SEL_WAKE_TAP));

endmodule

// File: rtl/lpm_period_timer.sv
module lpm_period_timer #(
    parameter int TW = 8
) (
    input  logic          clk_i,
    input  logic          rst_n_i,
    input  logic          clr_i,
    input  logic          tick_i,
    input  logic          cascade_i,
    input  logic [TW-1:0] cmp_lo_i,
    input  logic [TW-1:0] cmp_hi_i,
    output logic          match_o
);
    localparam int CW = 2 * TW;

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] cmp_full;

    assign cmp_full = cascade_i ? {cmp_hi_i, cmp_lo_i} : {{TW{1'b0}}, cmp_lo_i};
    assign match_o  = tick_i && !clr_i && (cnt_q == cmp_full);

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i || match_o) begin
            cnt_d = '0;
        end else if (tick_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/lpm_stab_cnt.sv
module lpm_stab_cnt #(
    parameter int STAB_W = 18
) (
    input  logic clk_i,
    input  logic rst_n_i,
    output logic busy_o
);
    logic [STAB_W:0] cnt_d, cnt_q;

    assign busy_o = !cnt_q[STAB_W];

    always_comb begin
        cnt_d = cnt_q;
        if (busy_o) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/lpm_wake_ctrl.sv
module lpm_wake_ctrl #(
    parameter int TW            = 8,
    parameter int WAKE_DIV_LOG2 = 11,
    parameter int STAB_W        = 18
) (
    input  logic          clk_i,
    input  logic          rst_n_i,
    input  logic          stop_req_i,
    input  logic          ien_i,
    input  logic          ext_irq_i,
    input  logic          ctl_byte_wr_i,
    input  logic          ctl_bit_wr_i,
    input  logic          tdr0_wr_i,
    input  logic          tdr1_wr_i,
    input  logic [TW-1:0] wdata_i,
    output logic          cpu_clk_en_o,
    output logic          osc_en_o,
    output logic          int_rst_o,
    output logic          wake_vec_o,
    output logic          wake_resume_o
);
    import lpm_pkg::*;

    typedef struct packed {
        lpm_state_e    state;
        lpm_ctl_t      ctl;
        logic [TW-1:0] tdr0;
        logic [TW-1:0] tdr1;
        logic          vec;
        logic          resume;
    } lpm_regs_t;

    lpm_regs_t st_d, st_q;

    logic stab_busy;
    logic ps_tick;
    logic tmr_tick;
    logic tmr_match;
    logic sleep_entry;
    logic in_wake;
    logic byte_wr_ok;

    assign in_wake     = (st_q.state == LPM_WAKE_TMR);
    assign sleep_entry = (st_q.state == LPM_RUN) && stop_req_i && !stab_busy;
    assign byte_wr_ok  = ctl_byte_wr_i && !ctl_bit_wr_i;
    assign tmr_tick    = ps_tick && in_wake;

    lpm_stab_cnt #(.STAB_W(STAB_W)) u_stab (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .busy_o  (stab_busy)
    );

    lpm_prescaler #(.WAKE_DIV_LOG2(WAKE_DIV_LOG2)) u_ps (
        .clk_i       (clk_i),
        .rst_n_i     (rst_n_i),
        .run_i       (st_q.state != LPM_FULL_STOP),
        .clr_i       (sleep_entry),
        .wake_only_i (in_wake),
        .sel_i       (st_q.ctl.t0_sel),
        .tick_o      (ps_tick)
    );

    lpm_period_timer #(.TW(TW)) u_tmr (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n_i),
        .clr_i     (sleep_entry),
        .tick_i    (tmr_tick),
        .cascade_i (st_q.ctl.cascade),
        .cmp_lo_i  (st_q.tdr0),
        .cmp_hi_i  (st_q.tdr1),
        .match_o   (tmr_match)
    );

    always_comb begin
        st_d        = st_q;
        st_d.vec    = 1'b0;
        st_d.resume = 1'b0;

        if (byte_wr_ok) begin
            st_d.ctl = lpm_ctl_t'(wdata_i[CTL_W-1:0]);
        end
        if (tdr0_wr_i) begin
            st_d.tdr0 = wdata_i;
        end
        if (tdr1_wr_i) begin
            st_d.tdr1 = wdata_i;
        end

        unique case (st_q.state)
            LPM_RUN: begin
                if (sleep_entry) begin
                    st_d.state = st_q.ctl.wake_en ? LPM_WAKE_TMR : LPM_FULL_STOP;
                end
            end
            LPM_WAKE_TMR: begin
                if (ext_irq_i || tmr_match) begin
                    st_d.state  = LPM_RUN;
                    st_d.vec    = ien_i;
                    st_d.resume = !ien_i;
                end
            end
            LPM_FULL_STOP: begin
                st_d.state = LPM_FULL_STOP;
            end
            default: begin
                st_d.state = LPM_RUN;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            st_q <= '{state: LPM_RUN, ctl: '0, tdr0: '0, tdr1: '0,
                      vec: 1'b0, resume: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cpu_clk_en_o  = (st_q.state == LPM_RUN) && !stab_busy;
    assign osc_en_o      = (st_q.state != LPM_FULL_STOP);
    assign int_rst_o     = stab_busy;
    assign wake_vec_o    = st_q.vec;
    assign wake_resume_o = st_q.resume;

endmodule

// File: rtl/lpm_wake_ctrl_chk.sv
module lpm_wake_ctrl_chk (
    input logic       clk_i,
    input logic       rst_n_i,
    input logic       stop_req_i,
    input logic       ien_i,
    input logic       ext_irq_i,
    input logic       cpu_clk_en_o,
    input logic       osc_en_o,
    input logic       int_rst_o,
    input logic       wake_vec_o,
    input logic       wake_resume_o,
    input logic       in_wake,
    input logic       tmr_match,
    input logic [1:0] t0_sel
);
    import lpm_pkg::*;

    assert_full_stop_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $fell(osc_en_o) |-> ($past(stop_req_i) && $past(cpu_clk_en_o)));

    assert_tap_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (in_wake && tmr_match) |-> (t0_sel == SEL_WAKE_TAP));

    assert_irq_exit_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (in_wake && ext_irq_i) |=> cpu_clk_en_o);

    assert_one_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $onehot0({wake_vec_o, wake_resume_o}));

    assert_vec_follows_ien_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        wake_vec_o |-> $past(ien_i));

    assert_no_stab_delay_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (wake_vec_o || wake_resume_o) |-> (cpu_clk_en_o && osc_en_o));

    assert_rst_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        int_rst_o |-> !cpu_clk_en_o);

    assert_stop_blocked_R12: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        int_rst_o |=> osc_en_o);

endmodule

bind lpm_wake_ctrl lpm_wake_ctrl_chk u_chk (
    .clk_i         (clk_i),
    .rst_n_i       (rst_n_i),
    .stop_req_i    (stop_req_i),
    .ien_i         (ien_i),
    .ext_irq_i     (ext_irq_i),
    .cpu_clk_en_o  (cpu_clk_en_o),
    .osc_en_o      (osc_en_o),
    .int_rst_o     (int_rst_o),
    .wake_vec_o    (wake_vec_o),
    .wake_resume_o (wake_resume_o),
    .in_wake       (in_wake),
    .tmr_match     (tmr_match),
    .t0_sel        (st_q.ctl.t0_sel)
);

// File: tb/lpm_wake_ctrl_tb.sv
`timescale 1ns/1ps
module lpm_wake_ctrl_tb;

    localparam int TW     = 8;
    localparam int WDL    = 3;
    localparam int SW     = 5;
    localparam int DIV    = 1 << WDL;
    localparam int STAB_N = 1 << SW;
    localparam int C_VEC  = 1;
    localparam int C_RES  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_req = 1'b0, ien = 1'b0, ext_irq = 1'b0;
    logic ctl_byte_wr = 1'b0, ctl_bit_wr = 1'b0, tdr0_wr = 1'b0, tdr1_wr = 1'b0;
    logic [TW-1:0] wdata = '0;
    logic cpu_clk_en, osc_en, int_rst, wake_vec, wake_resume;

    always #5 clk = ~clk;

    lpm_wake_ctrl #(.TW(TW), .WAKE_DIV_LOG2(WDL), .STAB_W(SW)) u_dut (
        .clk_i(clk), .rst_n_i(rst_n), .stop_req_i(stop_req), .ien_i(ien),
        .ext_irq_i(ext_irq), .ctl_byte_wr_i(ctl_byte_wr), .ctl_bit_wr_i(ctl_bit_wr),
        .tdr0_wr_i(tdr0_wr), .tdr1_wr_i(tdr1_wr), .wdata_i(wdata),
        .cpu_clk_en_o(cpu_clk_en), .osc_en_o(osc_en), .int_rst_o(int_rst),
        .wake_vec_o(wake_vec), .wake_resume_o(wake_resume)
    );

    typedef struct {
        int    cause;
        int    lat;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   nvec = 0;
    int   nerr = 0;
    int   sleep_cnt = 0;
    bit   done = 1'b0;

    task automatic chk(input string req, input int act, input int expv);
        nvec++;
        if (act != expv) begin
            nerr++;
            $display("FAIL %s: got %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic push_exp(input int cause, input int lat, input string req);
        exp_t e;
        e.cause = cause;
        e.lat   = lat;
        e.req   = req;
        exp_q.push_back(e);
    endtask

    // monitor: scores every wake cause pulse against the queue
    always begin
        @(posedge clk);
        #1;
        if (!rst_n || int_rst) begin
            sleep_cnt = 0;
        end else begin
            if (!cpu_clk_en) sleep_cnt++;
            if (wake_vec || wake_resume) begin
                if (exp_q.size() == 0) begin
                    nvec++;
                    nerr++;
                    $display("FAIL R7: got unexpected wake pulse expected %0d", 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk({e.req, " cause"}, wake_vec ? C_VEC : C_RES, e.cause);
                    if (e.lat >= 0) chk({e.req, " latency"}, sleep_cnt, e.lat);
                    chk("R8 clock on with pulse", int'(cpu_clk_en), 1);
                end
                sleep_cnt = 0;
            end
        end
    end

    task automatic do_reset(input bit poke_stop);
        int n;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 int_rst during reset", int'(int_rst), 1);
        chk("R9 clock off during reset", int'(cpu_clk_en), 0);
        rst_n = 1'b1;
        n = 0;
        do begin
            @(posedge clk);
            #1;
            n++;
            if (poke_stop && n == 5) begin
                @(negedge clk) stop_req = 1'b1;
                @(posedge clk);
                #1;
                n++;
                stop_req = 1'b0;
            end
        end while (int_rst);
        chk("R9 stabilization length", n, STAB_N);
        chk("R12 clock runs after stab", int'(cpu_clk_en), 1);
        chk("R12 oscillator on after stab", int'(osc_en), 1);
    endtask

    task automatic wr_ctl(input int val);
        @(negedge clk);
        wdata = TW'(val);
        ctl_byte_wr = 1'b1;
        @(negedge clk);
        ctl_byte_wr = 1'b0;
    endtask

    task automatic wr_tdr(input int which, input int val);
        @(negedge clk);
        wdata = TW'(val);
        if (which == 0) tdr0_wr = 1'b1; else tdr1_wr = 1'b1;
        @(negedge clk);
        tdr0_wr = 1'b0;
        tdr1_wr = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk);
        stop_req = 1'b1;
        @(posedge clk);
        #1;
        stop_req = 1'b0;
    endtask

    task automatic wait_awake();
        while (!cpu_clk_en) begin
            @(posedge clk);
            #1;
        end
        @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nvec++;
            nerr++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            summary();
        end
    end

    initial begin
        // R9, R12: power-up stabilization with a stop request poked in the window
        do_reset(1'b1);

        // R11: byte write sets wake mode, bit strobe must not clear it
        wr_ctl(4'b0111);
        @(negedge clk);
        wdata = '0;
        ctl_bit_wr = 1'b1;
        ctl_byte_wr = 1'b1;
        @(negedge clk);
        ctl_byte_wr = 1'b0;
        @(negedge clk);
        ctl_bit_wr = 1'b0;
        wr_tdr(0, 3);

        // R1, R3, R7 vector cause
        ien = 1'b1;
        push_exp(C_VEC, 4 * DIV, "R3 timer wake");
        do_stop();
        chk("R1 clock gated", int'(cpu_clk_en), 0);
        chk("R1 oscillator kept", int'(osc_en), 1);
        chk("R11 bit strobe ignored (timed sleep)", int'(osc_en), 1);
        wait_awake();

        // R10 settings kept, R7 resume cause
        ien = 1'b0;
        push_exp(C_RES, 4 * DIV, "R10 repeat without reprogram");
        do_stop();
        wait_awake();

        // R3 boundary: period zero
        wr_tdr(0, 0);
        ien = 1'b1;
        push_exp(C_VEC, DIV, "R3 period zero");
        do_stop();
        wait_awake();

        // R3 boundary: full 8-bit period
        wr_tdr(0, 255);
        push_exp(C_VEC, 256 * DIV, "R3 period max");
        do_stop();
        wait_awake();

        // R5 cascaded period {1,2} = 258
        wr_ctl(4'b1111);
        wr_tdr(1, 1);
        wr_tdr(0, 2);
        push_exp(C_VEC, 259 * DIV, "R5 cascade");
        do_stop();
        wait_awake();

        // R4: non-wake tap never wakes; R6 external interrupt ends sleep
        wr_ctl(4'b0101);
        wr_tdr(0, 0);
        ien = 1'b0;
        do_stop();
        repeat (3000) @(posedge clk);
        #1;
        chk("R4 no wake on other tap", int'(cpu_clk_en), 0);
        push_exp(C_RES, -1, "R6 irq wake");
        @(negedge clk);
        ext_irq = 1'b1;
        @(posedge clk);
        #1;
        ext_irq = 1'b0;
        chk("R6 clock back on irq edge", int'(cpu_clk_en), 1);
        @(negedge clk);

        // R2: full stop ignores interrupts
        wr_ctl(4'b0110);
        ien = 1'b1;
        do_stop();
        chk("R2 oscillator stopped", int'(osc_en), 0);
        chk("R2 clock gated", int'(cpu_clk_en), 0);
        @(negedge clk);
        ext_irq = 1'b1;
        repeat (2) @(negedge clk);
        ext_irq = 1'b0;
        repeat (40) @(posedge clk);
        #1;
        chk("R2 irq ignored in full stop", int'(cpu_clk_en), 0);
        chk("R2 oscillator still off", int'(osc_en), 0);

        // R9: reset exit, then registers must be cleared
        do_reset(1'b0);
        wr_ctl(4'b0111);
        wr_tdr(0, 5);
        do_reset(1'b0);
        do_stop();
        chk("R9 control cleared by reset", int'(osc_en), 0);
        do_reset(1'b0);
        chk("R7 no stray expected items", exp_q.size(), 0);

        done = 1'b1;
        summary();
    end

endmodule